// File: doc/BRIEF.md
# Receive Packet Validation and Reassembly

This block sits on the receive side of a network interface in which the sender chooses where each message lands in the receiver's memory. Every arriving packet header names a slot, a per-message metadata entry, a 64-bit protection key, an offset, a length and a signed delta. The block looks the slot up in a small on-chip table and checks the key and the bounds. For a good packet it issues a DMA write command at slot base plus offset. For a bad one it emits a reject strobe with a reason code and makes no memory write.

Message completion does not depend on a packet count. Each message owns a 32-bit accumulator in a metadata entry held in host memory. The block adds every packet's delta to that accumulator modulo 2^32 through a read-modify-write port. The message is complete when the sum comes back to zero, so packets may arrive in any order and one notification can cover a group of senders. A delta of zero completes at once. A metadata index of all ones carries one word of inline metadata and bypasses the accumulator.

Guarded slots check a second, per-message window and key, both fetched with the accumulator. One-shot slots also lock an entry once its message completes. A host handshake watchdog keeps the block in a drop-everything state until the host checks in, and puts it back there when the host stops doing so.

Top module: `rx_pkt_assembler`

## Requirements
- R1: From reset until the first `hs_kick`, and again once `WD_LIMIT` cycles pass with no `hs_kick`, every header is taken and rejected with code 1. No DMA command and no metadata access is made.
- R2: A header naming a slot whose valid bit is clear, or whose mode is 3, is rejected with code 2.
- R3: In a slot of mode 0 (normal), a header key that differs from the slot key is rejected with code 3. In modes 1 (guarded) and 2 (one-shot), the slot key is ignored and the per-message key returned by the metadata read is compared instead, with code 3 on mismatch.
- R4: A packet whose offset plus length (computed without overflow) exceeds the slot bound is rejected with code 4. An accepted packet produces one `dma_valid` pulse with `dma_addr` = slot base + offset and `dma_len` = length.
- R5: For a non-fast packet with a nonzero delta, the block reads the metadata entry and writes back accumulator + delta modulo 2^32. It signals `done_valid` exactly when that sum is zero.
- R6: A delta of zero signals completion on acceptance. In mode 0 it causes no metadata read and no metadata write.
- R7: A metadata index of all ones (fast mode) completes on acceptance with `done_fast` = 1 and `done_word` = the header word, and makes no metadata access. In modes 1 and 2 a fast header is rejected with code 5.
- R8: In modes 1 and 2, the packet range must also satisfy lo <= offset and offset + length <= hi, using the per-message window returned by the read. Otherwise it is rejected with code 5.
- R9: In mode 2, the write-back that completes a message sets the lock flag. A packet for an entry that the read reports as locked is rejected with code 6.
- R10: Checks are applied in this order, and the first failure sets the code: offline (1), slot (2), normal-mode key (3), primary bounds (4), fast-in-guarded (5), lock (6), per-message key (3), per-message window (5).
- R11: Only one metadata read is outstanding at a time. `hdr_ready` is low from the cycle the read is issued until the result is decided.
- R12: Each header produces exactly one of `dma_valid` or `rej_valid`. The pulse comes one cycle after acceptance when no read is needed, and one cycle after `md_rd_ack` otherwise. A reject never comes with a metadata write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_kick | input | 1 | Host handshake pulse that keeps the block online |
| cfg_we | input | 1 | Slot table write strobe |
| cfg_slot | input | SLOT_W | Slot table entry to write |
| cfg_valid | input | 1 | Valid bit for the written entry |
| cfg_mode | input | 2 | 0 normal, 1 guarded, 2 one-shot, 3 reserved |
| cfg_base | input | 32 | Message area base address |
| cfg_bound | input | 32 | Message area size in bytes |
| cfg_key | input | 64 | Slot protection key |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header taken when high together with hdr_valid |
| hdr_slot | input | SLOT_W | Slot number |
| hdr_mdidx | input | MD_W | Metadata entry index, all ones for fast mode |
| hdr_key | input | 64 | Packet protection key |
| hdr_offset | input | 32 | Offset inside the message area |
| hdr_len | input | 16 | Payload length in bytes |
| hdr_delta | input | 32 | Accumulator delta |
| hdr_word | input | 32 | Inline metadata word for fast mode |
| md_rd_req | output | 1 | Metadata entry read request pulse |
| md_rd_slot | output | SLOT_W | Slot of the entry to read |
| md_rd_idx | output | MD_W | Index of the entry to read |
| md_rd_ack | input | 1 | Read response pulse |
| md_rd_acc | input | 32 | Accumulator value read |
| md_rd_lo | input | 32 | Per-message window low offset |
| md_rd_hi | input | 32 | Per-message window high offset |
| md_rd_key | input | 64 | Per-message key |
| md_rd_locked | input | 1 | One-shot lock flag |
| md_wr_req | output | 1 | Metadata write-back pulse |
| md_wr_slot | output | SLOT_W | Slot of the entry written |
| md_wr_idx | output | MD_W | Index of the entry written |
| md_wr_acc | output | 32 | New accumulator value |
| md_wr_lock | output | 1 | New lock flag |
| dma_valid | output | 1 | DMA write command pulse |
| dma_addr | output | 32 | Destination address |
| dma_len | output | 16 | Transfer length |
| rej_valid | output | 1 | Reject pulse |
| rej_code | output | 3 | Reject reason |
| done_valid | output | 1 | Message completion pulse |
| done_slot | output | SLOT_W | Slot of the completed message |
| done_idx | output | MD_W | Metadata index of the completed message |
| done_fast | output | 1 | Completion came from a fast-mode header |
| done_word | output | 32 | Inline word for fast mode, zero otherwise |

## Verification
The assertions assume that the memory side answers each read with exactly one `md_rd_ack` pulse while a read is pending, and never raises it otherwise. They also assume the header fields stay stable while `hdr_valid` waits for `hdr_ready`. The bench's memory responder answers only the request it has captured, after a programmable latency. Its header task holds every field until the handshake completes and then drops `hdr_valid`.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int KEY_W  = 64;
  localparam int ACC_W  = 32;
  localparam int RJ_W   = 3;

  typedef enum logic [1:0] {
    MD_NORMAL  = 2'd0,
    MD_GUARDED = 2'd1,
    MD_ONESHOT = 2'd2,
    MD_RSVD    = 2'd3
  } slot_mode_e;

  typedef enum logic [RJ_W-1:0] {
    RJ_NONE    = 3'd0,
    RJ_OFFLINE = 3'd1,
    RJ_SLOT    = 3'd2,
    RJ_KEY     = 3'd3,
    RJ_PRIM    = 3'd4,
    RJ_SEC     = 3'd5,
    RJ_LOCK    = 3'd6
  } rej_code_e;

  typedef struct packed {
    logic              vld;
    slot_mode_e        mode;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] bound;
    logic [KEY_W-1:0]  key;
  } slot_ent_t;

  // end of packet range, one bit wider so it cannot wrap
  function automatic logic [ADDR_W:0] range_end(input logic [ADDR_W-1:0] off,
                                                input logic [LEN_W-1:0]  len);
    return {1'b0, off} + {{(ADDR_W + 1 - LEN_W){1'b0}}, len};
  endfunction

  function automatic logic fits_limit(input logic [ADDR_W-1:0] off,
                                      input logic [LEN_W-1:0]  len,
                                      input logic [ADDR_W-1:0] lim);
    return range_end(off, len) <= {1'b0, lim};
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] off,
                                     input logic [LEN_W-1:0]  len,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
    return (off >= lo) && fits_limit(off, len, hi);
  endfunction

  function automatic logic [ACC_W-1:0] acc_step(input logic [ACC_W-1:0] acc,
                                                input logic [ACC_W-1:0] delta);
    return acc + delta;
  endfunction

  function automatic logic is_guarded(input slot_mode_e m);
    return (m == MD_GUARDED) || (m == MD_ONESHOT);
  endfunction
endpackage

// File: rtl/rx_slot_table.sv
module rx_slot_table
  import rx_pkg::*;
#(
  parameter int SLOT_N = 16,
  localparam int SLOT_W = $clog2(SLOT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  slot_ent_t         wr_ent,
  input  logic [SLOT_W-1:0] rd_idx,
  output slot_ent_t         rd_ent
);
  slot_ent_t ent_q [SLOT_N];

  for (genvar g = 0; g < SLOT_N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (wr_en && (wr_idx == SLOT_W'(g))) begin
        ent_q[g] <= wr_ent;
      end
    end
  end

  assign rd_ent = ent_q[rd_idx];
endmodule

// File: rtl/rx_hs_watchdog.sv
module rx_hs_watchdog #(
  parameter int WD_LIMIT = 4096,
  localparam int CNT_W = $clog2(WD_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic online
);
  logic [CNT_W-1:0] cnt_q;
  logic             online_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      online_q <= 1'b0;
    end else if (kick) begin
      cnt_q    <= '0;
      online_q <= 1'b1;
    end else if (online_q) begin
      if (cnt_q == CNT_W'(WD_LIMIT - 1)) begin
        cnt_q    <= '0;
        online_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign online = online_q;
endmodule

// File: rtl/rx_pkt_check.sv
module rx_pkt_check
  import rx_pkg::*;
(
  // first pass: header against slot entry
  input  logic              online,
  input  slot_ent_t         ent,
  input  logic [KEY_W-1:0]  in_key,
  input  logic [ADDR_W-1:0] in_off,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [ACC_W-1:0]  in_delta,
  input  logic              in_fast,
  output rej_code_e         s1_code,
  output logic              s1_fetch,
  // second pass: latched header against metadata entry
  input  slot_mode_e        s2_mode,
  input  logic [KEY_W-1:0]  s2_key,
  input  logic [ADDR_W-1:0] s2_off,
  input  logic [LEN_W-1:0]  s2_len,
  input  logic [ACC_W-1:0]  s2_delta,
  input  logic [ACC_W-1:0]  md_acc,
  input  logic [ADDR_W-1:0] md_lo,
  input  logic [ADDR_W-1:0] md_hi,
  input  logic [KEY_W-1:0]  md_key,
  input  logic              md_locked,
  output rej_code_e         s2_code,
  output logic [ACC_W-1:0]  s2_acc,
  output logic              s2_done
);
  logic grd1, grd2;

  assign grd1 = is_guarded(ent.mode);
  assign grd2 = is_guarded(s2_mode);

  always_comb begin
    if (!online)                                  s1_code = RJ_OFFLINE;
    else if (!ent.vld || ent.mode == MD_RSVD)     s1_code = RJ_SLOT;
    else if (!grd1 && (in_key != ent.key))        s1_code = RJ_KEY;
    else if (!fits_limit(in_off, in_len, ent.bound)) s1_code = RJ_PRIM;
    else if (grd1 && in_fast)                     s1_code = RJ_SEC;
    else                                          s1_code = RJ_NONE;
  end

  assign s1_fetch = (s1_code == RJ_NONE) && !in_fast &&
                    (grd1 || (in_delta != '0));

  always_comb begin
    if ((s2_mode == MD_ONESHOT) && md_locked)              s2_code = RJ_LOCK;
    else if (grd2 && (s2_key != md_key))                   s2_code = RJ_KEY;
    else if (grd2 && !in_window(s2_off, s2_len, md_lo, md_hi)) s2_code = RJ_SEC;
    else                                                   s2_code = RJ_NONE;
  end

  assign s2_acc  = acc_step(md_acc, s2_delta);
  assign s2_done = (s2_delta == '0) || (s2_acc == '0);
endmodule

// File: rtl/rx_pkt_assembler.sv
module rx_pkt_assembler
  import rx_pkg::*;
#(
  parameter int SLOT_N   = 16,
  parameter int MD_W     = 8,
  parameter int WD_LIMIT = 4096,
  localparam int SLOT_W  = $clog2(SLOT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_kick,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_mode,
  input  logic [31:0]       cfg_base,
  input  logic [31:0]       cfg_bound,
  input  logic [63:0]       cfg_key,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [SLOT_W-1:0] hdr_slot,
  input  logic [MD_W-1:0]   hdr_mdidx,
  input  logic [63:0]       hdr_key,
  input  logic [31:0]       hdr_offset,
  input  logic [15:0]       hdr_len,
  input  logic [31:0]       hdr_delta,
  input  logic [31:0]       hdr_word,
  output logic              md_rd_req,
  output logic [SLOT_W-1:0] md_rd_slot,
  output logic [MD_W-1:0]   md_rd_idx,
  input  logic              md_rd_ack,
  input  logic [31:0]       md_rd_acc,
  input  logic [31:0]       md_rd_lo,
  input  logic [31:0]       md_rd_hi,
  input  logic [63:0]       md_rd_key,
  input  logic              md_rd_locked,
  output logic              md_wr_req,
  output logic [SLOT_W-1:0] md_wr_slot,
  output logic [MD_W-1:0]   md_wr_idx,
  output logic [31:0]       md_wr_acc,
  output logic              md_wr_lock,
  output logic              dma_valid,
  output logic [31:0]       dma_addr,
  output logic [15:0]       dma_len,
  output logic              rej_valid,
  output logic [2:0]        rej_code,
  output logic              done_valid,
  output logic [SLOT_W-1:0] done_slot,
  output logic [MD_W-1:0]   done_idx,
  output logic              done_fast,
  output logic [31:0]       done_word
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e               st_q;
  slot_ent_t         cfg_ent, rd_ent;
  logic              online_w;
  logic              take_w, fast_w, resolve_w;
  rej_code_e         s1_code_w, s2_code_w;
  logic              s1_fetch_w, s2_done_w;
  logic [ACC_W-1:0]  s2_acc_w;

  // header held while the metadata read is in flight
  logic [SLOT_W-1:0] h_slot;
  logic [MD_W-1:0]   h_idx;
  logic [KEY_W-1:0]  h_key;
  logic [ADDR_W-1:0] h_off, h_base;
  logic [LEN_W-1:0]  h_len;
  logic [ACC_W-1:0]  h_delta;
  slot_mode_e        h_mode;

  assign cfg_ent = '{vld: cfg_valid, mode: slot_mode_e'(cfg_mode),
                     base: cfg_base, bound: cfg_bound, key: cfg_key};

  rx_slot_table #(.SLOT_N(SLOT_N)) i_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_idx (cfg_slot),
    .wr_ent (cfg_ent),
    .rd_idx (hdr_slot),
    .rd_ent (rd_ent)
  );

  rx_hs_watchdog #(.WD_LIMIT(WD_LIMIT)) i_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (hs_kick),
    .online (online_w)
  );

  assign hdr_ready = (st_q == ST_IDLE);
  assign take_w    = hdr_valid && hdr_ready;
  assign fast_w    = &hdr_mdidx;
  assign resolve_w = (st_q == ST_WAIT) && md_rd_ack;

  rx_pkt_check i_check (
    .online    (online_w),
    .ent       (rd_ent),
    .in_key    (hdr_key),
    .in_off    (hdr_offset),
    .in_len    (hdr_len),
    .in_delta  (hdr_delta),
    .in_fast   (fast_w),
    .s1_code   (s1_code_w),
    .s1_fetch  (s1_fetch_w),
    .s2_mode   (h_mode),
    .s2_key    (h_key),
    .s2_off    (h_off),
    .s2_len    (h_len),
    .s2_delta  (h_delta),
    .md_acc    (md_rd_acc),
    .md_lo     (md_rd_lo),
    .md_hi     (md_rd_hi),
    .md_key    (md_rd_key),
    .md_locked (md_rd_locked),
    .s2_code   (s2_code_w),
    .s2_acc    (s2_acc_w),
    .s2_done   (s2_done_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      h_slot     <= '0;
      h_idx      <= '0;
      h_key      <= '0;
      h_off      <= '0;
      h_base     <= '0;
      h_len      <= '0;
      h_delta    <= '0;
      h_mode     <= MD_NORMAL;
      md_rd_req  <= 1'b0;
      md_rd_slot <= '0;
      md_rd_idx  <= '0;
      md_wr_req  <= 1'b0;
      md_wr_slot <= '0;
      md_wr_idx  <= '0;
      md_wr_acc  <= '0;
      md_wr_lock <= 1'b0;
      dma_valid  <= 1'b0;
      dma_addr   <= '0;
      dma_len    <= '0;
      rej_valid  <= 1'b0;
      rej_code   <= '0;
      done_valid <= 1'b0;
      done_slot  <= '0;
      done_idx   <= '0;
      done_fast  <= 1'b0;
      done_word  <= '0;
    end else begin
      md_rd_req  <= 1'b0;
      md_wr_req  <= 1'b0;
      md_wr_lock <= 1'b0;
      dma_valid  <= 1'b0;
      rej_valid  <= 1'b0;
      done_valid <= 1'b0;
      if (take_w) begin
        h_slot  <= hdr_slot;
        h_idx   <= hdr_mdidx;
        h_key   <= hdr_key;
        h_off   <= hdr_offset;
        h_base  <= rd_ent.base;
        h_len   <= hdr_len;
        h_delta <= hdr_delta;
        h_mode  <= rd_ent.mode;
        if (s1_fetch_w) begin
          md_rd_req  <= 1'b1;
          md_rd_slot <= hdr_slot;
          md_rd_idx  <= hdr_mdidx;
          st_q       <= ST_WAIT;
        end else if (s1_code_w != RJ_NONE) begin
          rej_valid <= 1'b1;
          rej_code  <= s1_code_w;
        end else begin
          // fast header or zero delta in a normal slot: complete now
          dma_valid  <= 1'b1;
          dma_addr   <= rd_ent.base + hdr_offset;
          dma_len    <= hdr_len;
          done_valid <= 1'b1;
          done_slot  <= hdr_slot;
          done_idx   <= hdr_mdidx;
          done_fast  <= fast_w;
          done_word  <= fast_w ? hdr_word : '0;
        end
      end else if (resolve_w) begin
        st_q <= ST_IDLE;
        if (s2_code_w != RJ_NONE) begin
          rej_valid <= 1'b1;
          rej_code  <= s2_code_w;
        end else begin
          dma_valid <= 1'b1;
          dma_addr  <= h_base + h_off;
          dma_len   <= h_len;
          if ((h_delta != '0) || ((h_mode == MD_ONESHOT) && s2_done_w)) begin
            md_wr_req  <= 1'b1;
            md_wr_slot <= h_slot;
            md_wr_idx  <= h_idx;
            md_wr_acc  <= s2_acc_w;
            md_wr_lock <= (h_mode == MD_ONESHOT) && s2_done_w;
          end
          if (s2_done_w) begin
            done_valid <= 1'b1;
            done_slot  <= h_slot;
            done_idx   <= h_idx;
            done_fast  <= 1'b0;
            done_word  <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rx_pkt_checker.sv
module rx_pkt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       online,
  input logic       hdr_valid,
  input logic       hdr_ready,
  input logic       md_rd_req,
  input logic       md_wr_req,
  input logic       md_wr_lock,
  input logic       dma_valid,
  input logic       rej_valid,
  input logic [2:0] rej_code,
  input logic       done_valid,
  input logic       done_fast
);
  // R1: offline header turns into an offline reject next cycle
  a_r1_offline_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && !online) |=> (rej_valid && rej_code == 3'd1));

  // R12: accept and reject never together
  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_valid && rej_valid));

  // R12: a reject never writes metadata
  a_r12_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> !md_wr_req);

  // R5: completion only on an accepted packet
  a_r5_done_with_dma: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> dma_valid);

  // R11: no new header while a read is out
  a_r11_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    md_rd_req |-> !hdr_ready);

  // R7: fast completion makes no write-back
  a_r7_fast_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fast) |-> !md_wr_req);

  // R9: lock is only set by a completing write-back
  a_r9_lock_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    md_wr_lock |-> (md_wr_req && done_valid));
endmodule

bind rx_pkt_assembler rx_pkt_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .online     (online_w),
  .hdr_valid  (hdr_valid),
  .hdr_ready  (hdr_ready),
  .md_rd_req  (md_rd_req),
  .md_wr_req  (md_wr_req),
  .md_wr_lock (md_wr_lock),
  .dma_valid  (dma_valid),
  .rej_valid  (rej_valid),
  .rej_code   (rej_code),
  .done_valid (done_valid),
  .done_fast  (done_fast)
);

// File: tb/test_rx_pkt_assembler.sv
module test_rx_pkt_assembler;
  localparam int CLK_PERIOD = 10;
  localparam int WD = 64;

  logic clk = 0, rst_n = 0, hs_kick = 0;
  logic cfg_we = 0, cfg_valid = 0;
  logic [3:0] cfg_slot = 0;
  logic [1:0] cfg_mode = 0;
  logic [31:0] cfg_base = 0, cfg_bound = 0;
  logic [63:0] cfg_key = 0;
  logic hdr_valid = 0, hdr_ready;
  logic [3:0] hdr_slot = 0;
  logic [7:0] hdr_mdidx = 0;
  logic [63:0] hdr_key = 0;
  logic [31:0] hdr_offset = 0, hdr_delta = 0, hdr_word = 0;
  logic [15:0] hdr_len = 0;
  logic md_rd_req, md_rd_ack = 0, md_rd_locked = 0;
  logic [3:0] md_rd_slot, md_wr_slot, done_slot;
  logic [7:0] md_rd_idx, md_wr_idx, done_idx;
  logic [31:0] md_rd_acc = 0, md_rd_lo = 0, md_rd_hi = 0;
  logic [63:0] md_rd_key = 0;
  logic md_wr_req, md_wr_lock, dma_valid, rej_valid, done_valid, done_fast;
  logic [31:0] md_wr_acc, dma_addr, done_word;
  logic [15:0] dma_len;
  logic [2:0] rej_code;

  rx_pkt_assembler #(.SLOT_N(16), .MD_W(8), .WD_LIMIT(WD)) i_rx_pkt_assembler (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;

  // host metadata memory model: 8 slots x 8 entries
  logic [31:0] mem_acc [64];
  logic [31:0] mem_lo [64];
  logic [31:0] mem_hi [64];
  logic [63:0] mem_key [64];
  logic        mem_lock [64];
  int rd_cnt = 0, wr_cnt = 0, resp_lat = 0, lat_cnt = 0, pi = 0;
  logic pend = 0;
  logic kick_en = 0;
  int cyc = 0;

  function automatic int mi(input logic [3:0] s, input logic [7:0] ix);
    return int'({s[2:0], ix[2:0]});
  endfunction

  always @(negedge clk) begin
    cyc++;
    hs_kick = kick_en && (cyc % 16 == 0);
  end

  always @(negedge clk) begin
    md_rd_ack = 0;
    if (md_wr_req === 1'b1) begin
      mem_acc[mi(md_wr_slot, md_wr_idx)]  = md_wr_acc;
      mem_lock[mi(md_wr_slot, md_wr_idx)] = md_wr_lock;
      wr_cnt++;
    end
    if (pend) begin
      if (lat_cnt == 0) begin
        md_rd_ack    = 1;
        md_rd_acc    = mem_acc[pi];
        md_rd_lo     = mem_lo[pi];
        md_rd_hi     = mem_hi[pi];
        md_rd_key    = mem_key[pi];
        md_rd_locked = mem_lock[pi];
        pend = 0;
      end else lat_cnt--;
    end else if (md_rd_req === 1'b1) begin
      pend = 1; lat_cnt = resp_lat; pi = mi(md_rd_slot, md_rd_idx); rd_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  logic o_dma, o_rej, o_done, o_fast;
  logic [31:0] o_addr, o_word;
  logic [15:0] o_len;
  logic [2:0] o_code;
  int o_lat;

  task automatic send(input logic [3:0] s, input logic [7:0] ix, input logic [63:0] k,
                      input logic [31:0] off, input logic [15:0] ln,
                      input logic [31:0] dl, input logic [31:0] wd);
    int n;
    @(negedge clk);
    hdr_valid = 1; hdr_slot = s; hdr_mdidx = ix; hdr_key = k;
    hdr_offset = off; hdr_len = ln; hdr_delta = dl; hdr_word = wd;
    while (!hdr_ready) @(negedge clk);
    @(negedge clk);
    hdr_valid = 0;
    n = 1;
    while (!(dma_valid || rej_valid) && n < 40) begin
      chk("R11 ready low while waiting", 64'(hdr_ready), 0);
      @(negedge clk);
      n++;
    end
    o_dma = dma_valid; o_rej = rej_valid; o_done = done_valid; o_fast = done_fast;
    o_addr = dma_addr; o_len = dma_len; o_code = rej_code; o_word = done_word; o_lat = n;
    @(posedge clk); #1;
  endtask

  task automatic exp_ok(input string tag, input logic [31:0] addr, input logic [15:0] ln,
                        input logic dn);
    chk({tag, " accept"}, 64'(o_dma), 1);
    chk({tag, " no reject"}, 64'(o_rej), 0);
    chk({tag, " addr"}, 64'(o_addr), 64'(addr));
    chk({tag, " len"}, 64'(o_len), 64'(ln));
    chk({tag, " done"}, 64'(o_done), 64'(dn));
  endtask

  task automatic exp_rej(input string tag, input logic [2:0] code);
    chk({tag, " reject"}, 64'(o_rej), 1);
    chk({tag, " code"}, 64'(o_code), 64'(code));
    chk({tag, " no dma"}, 64'(o_dma), 0);
    chk({tag, " no done"}, 64'(o_done), 0);
  endtask

  task automatic cfg(input logic [3:0] s, input logic v, input logic [1:0] m,
                     input logic [31:0] b, input logic [31:0] bd, input logic [63:0] k);
    @(negedge clk);
    cfg_we = 1; cfg_slot = s; cfg_valid = v; cfg_mode = m;
    cfg_base = b; cfg_bound = bd; cfg_key = k;
    @(negedge clk);
    cfg_we = 0;
  endtask

  localparam logic [63:0] K0  = 64'hA5A5_0000_1111_2222;
  localparam logic [63:0] K1  = 64'h1111_2222_3333_4444;
  localparam logic [63:0] K2  = 64'h5555_6666_7777_8888;
  localparam logic [63:0] KS1 = 64'h0BAD_F00D_0000_0001;
  localparam logic [63:0] KS2 = 64'h0BAD_F00D_0000_0002;

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r0, w0;
    logic [31:0] acc;
    for (int i = 0; i < 64; i++) begin
      mem_acc[i] = 0; mem_lo[i] = 0; mem_hi[i] = 0; mem_key[i] = 0; mem_lock[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset ready", 64'(hdr_ready), 1);
    chk("R12 reset dma", 64'(dma_valid), 0);
    chk("R12 reset rej", 64'(rej_valid), 0);
    chk("R5 reset done", 64'(done_valid), 0);
    chk("R11 reset rd", 64'(md_rd_req), 0);

    cfg(0, 1, 0, 32'h1000_0000, 32'h100, K0);
    cfg(1, 1, 1, 32'h2000_0000, 32'h1000, K1);
    cfg(2, 1, 2, 32'h3000_0000, 32'h1000, K2);
    cfg(3, 0, 0, 32'h4000_0000, 32'h1000, K0);
    cfg(4, 1, 3, 32'h5000_0000, 32'h1000, K0);

    // R1: offline before the first handshake
    r0 = rd_cnt;
    send(0, 1, K0, 0, 16, 0, 0);
    exp_rej("R1 power-up", 3'd1);
    chk("R1 no read", 64'(rd_cnt - r0), 0);
    kick_en = 1;
    repeat (20) @(negedge clk);

    // R4/R6: bounds sweep on a normal slot with zero delta
    for (int oi = 0; oi < 6; oi++) begin
      for (int li = 0; li < 4; li++) begin
        logic [31:0] off;
        logic [15:0] ln;
        off = (oi == 4) ? 32'hF0 : (oi == 5) ? 32'h100 : 32'(oi * 32'h40);
        ln  = (li == 0) ? 16'h0 : 16'(16 << (2 * (li - 1)));
        r0 = rd_cnt; w0 = wr_cnt;
        send(0, 1, K0, off, ln, 0, 0);
        if (off + 32'(ln) <= 32'h100) begin
          exp_ok("R4 sweep", 32'h1000_0000 + off, ln, 1);
          chk("R12 latency no read", 64'(o_lat), 1);
          chk("R6 no read", 64'(rd_cnt - r0), 0);
          chk("R6 no write", 64'(wr_cnt - w0), 0);
        end else exp_rej("R4 sweep", 3'd4);
      end
    end
    // offset near the top of the address space must not wrap into range
    send(0, 1, K0, 32'hFFFF_FFF0, 16'h20, 0, 0);
    exp_rej("R4 wrap", 3'd4);

    // R3 and R10 in a normal slot
    send(0, 1, K1, 0, 16, 0, 0);
    exp_rej("R3 key", 3'd3);
    send(0, 1, K1, 32'h200, 16, 0, 0);
    exp_rej("R10 key before bounds", 3'd3);

    // R2
    send(3, 1, K0, 0, 16, 0, 0);
    exp_rej("R2 invalid slot", 3'd2);
    send(4, 1, K0, 0, 16, 0, 0);
    exp_rej("R2 reserved mode", 3'd2);
    send(3, 1, K1, 32'h9000, 16, 0, 0);
    exp_rej("R10 slot before key", 3'd2);

    // R5: out-of-order arrival, deltas 1,1,-2 sent last first
    acc = 0;
    send(0, 2, K0, 32'h40, 16, 32'hFFFF_FFFE, 0);
    acc = acc + 32'hFFFF_FFFE;
    exp_ok("R5 pkt a", 32'h1000_0040, 16, 0);
    chk("R12 latency with read", 64'(o_lat), 3);
    chk("R5 acc a", 64'(mem_acc[mi(0, 2)]), 64'(acc));
    send(0, 2, K0, 0, 16, 1, 0);
    acc = acc + 1;
    exp_ok("R5 pkt b", 32'h1000_0000, 16, 0);
    chk("R5 acc b", 64'(mem_acc[mi(0, 2)]), 64'(acc));
    send(0, 2, K0, 32'h20, 16, 1, 0);
    acc = acc + 1;
    exp_ok("R5 pkt c", 32'h1000_0020, 16, 1);
    chk("R5 acc zero", 64'(mem_acc[mi(0, 2)]), 64'(acc));
    // group of two senders
    send(0, 3, K0, 0, 8, 32'h4000_0000, 0);
    exp_ok("R5 group first", 32'h1000_0000, 8, 0);
    send(0, 3, K0, 8, 8, 32'hC000_0000, 0);
    exp_ok("R5 group last", 32'h1000_0008, 8, 1);
    // zero delta ignores a nonzero accumulator
    mem_acc[mi(0, 2)] = 32'd7;
    r0 = rd_cnt; w0 = wr_cnt;
    send(0, 2, K0, 0, 4, 0, 0);
    exp_ok("R6 zero delta", 32'h1000_0000, 4, 1);
    chk("R6 acc untouched", 64'(mem_acc[mi(0, 2)]), 7);
    chk("R6 zero delta no write", 64'(wr_cnt - w0), 0);
    // longer response latency
    resp_lat = 4;
    send(0, 4, K0, 0, 4, 5, 0);
    exp_ok("R11 slow read", 32'h1000_0000, 4, 0);
    chk("R12 slow latency", 64'(o_lat), 7);
    resp_lat = 0;

    // R7 fast mode
    r0 = rd_cnt; w0 = wr_cnt;
    send(0, 8'hFF, K0, 32'h10, 32, 5, 32'hDEAD_BEEF);
    exp_ok("R7 fast", 32'h1000_0010, 32, 1);
    chk("R7 fast flag", 64'(o_fast), 1);
    chk("R7 fast word", 64'(o_word), 64'h DEAD_BEEF);
    chk("R7 no read", 64'(rd_cnt - r0), 0);
    chk("R7 no write", 64'(wr_cnt - w0), 0);
    send(1, 8'hFF, K1, 0, 16, 0, 1);
    exp_rej("R7 fast guarded", 3'd5);

    // R8 guarded slot
    mem_lo[mi(1, 0)] = 32'h100; mem_hi[mi(1, 0)] = 32'h200; mem_key[mi(1, 0)] = KS1;
    send(1, 0, K1, 32'h100, 16'h80, 0, 0);
    exp_rej("R3 slot key ignored", 3'd3);
    w0 = wr_cnt;
    send(1, 0, KS1, 32'h100, 16'h80, 0, 0);
    exp_ok("R8 inside window", 32'h2000_0100, 16'h80, 1);
    chk("R8 zero delta no write", 64'(wr_cnt - w0), 0);
    send(1, 0, KS1, 32'h180, 16'h100, 0, 0);
    exp_rej("R8 past hi", 3'd5);
    send(1, 0, KS1, 32'h80, 16'h10, 0, 0);
    exp_rej("R8 below lo", 3'd5);
    r0 = rd_cnt;
    send(1, 0, KS1, 32'hFF0, 16'h20, 0, 0);
    exp_rej("R10 primary before fetch", 3'd4);
    chk("R10 no read", 64'(rd_cnt - r0), 0);

    // R9 one-shot
    mem_lo[mi(2, 1)] = 0; mem_hi[mi(2, 1)] = 32'h1000; mem_key[mi(2, 1)] = KS2;
    send(2, 1, KS2, 0, 16, 1, 0);
    exp_ok("R9 first pkt", 32'h3000_0000, 16, 0);
    chk("R9 not locked yet", 64'(mem_lock[mi(2, 1)]), 0);
    send(2, 1, KS2, 16, 16, 32'hFFFF_FFFF, 0);
    exp_ok("R9 last pkt", 32'h3000_0010, 16, 1);
    chk("R9 locked", 64'(mem_lock[mi(2, 1)]), 1);
    send(2, 1, KS2, 0, 16, 0, 0);
    exp_rej("R9 locked reject", 3'd6);
    send(2, 1, K0, 0, 16, 0, 0);
    exp_rej("R10 lock before key", 3'd6);
    mem_lock[mi(2, 1)] = 0; mem_acc[mi(2, 1)] = 0;
    w0 = wr_cnt;
    send(2, 1, KS2, 0, 16, 0, 0);
    exp_ok("R9 rearmed", 32'h3000_0000, 16, 1);
    chk("R9 lock write", 64'(wr_cnt - w0), 1);
    chk("R9 relocked", 64'(mem_lock[mi(2, 1)]), 1);

    // R1 handshake timeout and recovery
    kick_en = 0;
    repeat (WD + 10) @(negedge clk);
    send(0, 1, K0, 0, 16, 0, 0);
    exp_rej("R1 timeout", 3'd1);
    kick_en = 1;
    repeat (20) @(negedge clk);
    send(0, 1, K0, 0, 16, 0, 0);
    exp_ok("R1 back online", 32'h1000_0000, 16, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule